// File: doc/BRIEF.md
# Serial Port Enable and Presence Register

This block holds one 32-bit control and status word for a group of up to eight serial storage ports. Each port owns one software-writable enable bit and one hardware-maintained presence bit. The enable bit is the master on/off switch for the port. It overrides the port's spin-up control. Setting it launches a link reset request toward the PHY. Clearing it starts an ordered, timed shutdown that removes the port's presence bit some cycles later, never in the cycle of the clearing write.

A per-port disable map can force any enable bit to a read-only zero. Presence is recorded only when the PHY's device-answer event (COMINIT) follows a reset request (COMRESET) that this block issued. Only the power-on reset clears the register. A function-level reset input is accepted and has no effect on any bit. A busy output stays high while the staggered shutdown is running, so the time it takes can be bounded.

Top module: `port_link_ctl`

## Requirements
- R1: The read word places port i's enable at bit i (bits 7:0) and port i's presence at bit 16+i (bits 23:16). Bits 15:8 and 31:24 always read 0, even after writing ones to them.
- R2: While `por_n` is low, every enable and presence bit, `comreset_req`, `port_active` and `shutdown_busy` are 0 at the next clock edge.
- R3: Pulsing `flr` changes no bit of the read word and no output.
- R4: A port whose `disable_map` bit is 1 reads enable 0 and ignores writes. If the map bit goes to 1 while the port is enabled, its enable clears at the next edge.
- R5: A presence bit is set one edge after COMINIT arrives on an enabled port that has an unanswered COMRESET request. COMINIT on a port with no outstanding request, or on a disabled port, is ignored.
- R6: A write that takes an enable bit from 0 to 1 produces a `comreset_req` pulse of exactly one cycle for that port, visible in the same cycle as the new enable value. Rewriting a 1 produces no pulse.
- R7: Writes to bits 23:16 have no effect on the presence bits.
- R8: `port_active[i]` is registered as enable(next) AND `spinup[i]`, so a port with enable 0 is never active, whatever `spinup` says.
- R9: Ports whose enable falls are shut down in ascending index order, one slot of STEP_CYCLES+1 cycles each. The j-th port in that order (j counted from 0) loses its presence bit (j+1)*(STEP_CYCLES+1) edges after the edge at which its enable fell.
- R10: `shutdown_busy` rises at the edge where an enable falls and falls when the last queued port has been cleared. With the defaults (STEP_CYCLES=16, 8 ns clock) it stays high at most 175 cycles (1.4 µs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| flr | input | 1 | Function-level reset; deliberately ignored |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| disable_map | input | NUM_PORTS | Per-port force-disable |
| spinup | input | NUM_PORTS | Per-port spin-up control |
| cominit | input | NUM_PORTS | Device-answer event from PHY |
| comreset_req | output | NUM_PORTS | One-cycle link reset request to PHY |
| port_active | output | NUM_PORTS | Port allowed out of the off state |
| shutdown_busy | output | 1 | Staggered shutdown in progress |

## Verification
A wrong internal state shows up at the ports within one cycle. A stale armed flag lets an unsolicited COMINIT set a presence bit at the next edge. A bad edge detector shows up as a missing or doubled `comreset_req` pulse next to the enable change. Errors in the shutdown queue show up as a presence bit that clears in the wrong slot, or as `shutdown_busy` staying high too long. The per-cycle reference model catches that on the first wrong edge, well inside the 175-cycle bound.

// File: rtl/port_link_pkg.sv
package port_link_pkg;
    localparam int REG_W    = 32;
    localparam int PRES_LSB = 16;
    localparam int MAX_PORTS = 8;

    typedef struct packed {
        logic en;
        logic armed;
        logic pres;
        logic crst;
        logic act;
    } lane_st_t;
endpackage

// File: rtl/plink_lane.sv
module plink_lane
    import port_link_pkg::*;
(
    input  logic clk,
    input  logic por_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic masked,
    input  logic cominit,
    input  logic spinup,
    input  logic clr,
    output logic en,
    output logic pres,
    output logic crst,
    output logic act,
    output logic fall
);
    lane_st_t st_q, st_d;
    logic accept;

    always_comb begin
        st_d   = st_q;
        accept = cominit & st_q.armed & st_q.en;
        if (masked)
            st_d.en = 1'b0;
        else if (wr_en)
            st_d.en = wr_bit;
        st_d.crst  = st_d.en & ~st_q.en;
        st_d.armed = st_d.crst | (st_q.armed & st_d.en & ~accept);
        st_d.pres  = clr ? 1'b0 : (st_q.pres | accept);
        st_d.act   = st_d.en & spinup;
        fall       = st_q.en & ~st_d.en;
    end

    always_ff @(posedge clk) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en   = st_q.en;
    assign pres = st_q.pres;
    assign crst = st_q.crst;
    assign act  = st_q.act;
endmodule

// File: rtl/plink_stagger.sv
module plink_stagger #(
    parameter int N           = 8,
    parameter int STEP_CYCLES = 16
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic [N-1:0] fall,
    output logic [N-1:0] clr,
    output logic         busy
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int TMR_W = $clog2(STEP_CYCLES + 1);

    typedef struct packed {
        logic [N-1:0]     pend;
        logic             active;
        logic [IDX_W-1:0] cur;
        logic [TMR_W-1:0] tmr;
    } eng_st_t;

    eng_st_t st_q, st_d;
    logic [IDX_W-1:0] low_idx;

    always_comb begin
        low_idx = '0;
        for (int i = N - 1; i >= 0; i--)
            if (st_q.pend[i]) low_idx = IDX_W'(i);
    end

    always_comb begin
        st_d = st_q;
        clr  = '0;
        if (st_q.active && st_q.tmr == '0)
            clr[st_q.cur] = 1'b1;
        if (st_q.active) begin
            if (st_q.tmr == '0) st_d.active = 1'b0;
            else                st_d.tmr    = st_q.tmr - 1'b1;
        end else if (st_q.pend != '0) begin
            st_d.active = 1'b1;
            st_d.cur    = low_idx;
            st_d.tmr    = TMR_W'(STEP_CYCLES - 1);
        end
        st_d.pend = (st_q.pend & ~clr) | fall;
    end

    always_ff @(posedge clk) begin
        if (!por_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.active | (st_q.pend != '0);
endmodule

// File: rtl/port_link_ctl.sv
module port_link_ctl
    import port_link_pkg::*;
#(
    parameter int NUM_PORTS   = 8,
    parameter int STEP_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 por_n,
    input  logic                 flr,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    output logic [REG_W-1:0]     rd_data,
    input  logic [NUM_PORTS-1:0] disable_map,
    input  logic [NUM_PORTS-1:0] spinup,
    input  logic [NUM_PORTS-1:0] cominit,
    output logic [NUM_PORTS-1:0] comreset_req,
    output logic [NUM_PORTS-1:0] port_active,
    output logic                 shutdown_busy
);
    logic [NUM_PORTS-1:0] en, pres, fall, clr;
    logic unused_ok;

    assign unused_ok = ^{flr, wr_data[REG_W-1:NUM_PORTS]};

    generate
        for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
            plink_lane u_lane (
                .clk     (clk),
                .por_n   (por_n),
                .wr_en   (wr_en),
                .wr_bit  (wr_data[p]),
                .masked  (disable_map[p]),
                .cominit (cominit[p]),
                .spinup  (spinup[p]),
                .clr     (clr[p]),
                .en      (en[p]),
                .pres    (pres[p]),
                .crst    (comreset_req[p]),
                .act     (port_active[p]),
                .fall    (fall[p])
            );
        end
    endgenerate

    plink_stagger #(.N(NUM_PORTS), .STEP_CYCLES(STEP_CYCLES)) u_stagger (
        .clk   (clk),
        .por_n (por_n),
        .fall  (fall),
        .clr   (clr),
        .busy  (shutdown_busy)
    );

    always_comb begin
        rd_data = '0;
        rd_data[NUM_PORTS-1:0]        = en;
        rd_data[PRES_LSB +: NUM_PORTS] = pres;
    end
endmodule

// File: rtl/port_link_ctl_chk.sv
module port_link_ctl_chk #(
    parameter int N          = 8,
    parameter int BUSY_LIMIT = 175
) (
    input logic         clk,
    input logic         por_n,
    input logic [31:0]  rd_data,
    input logic [N-1:0] disable_map,
    input logic [N-1:0] spinup,
    input logic [N-1:0] cominit,
    input logic [N-1:0] comreset_req,
    input logic [N-1:0] port_active,
    input logic         shutdown_busy
);
    int busy_cnt;

    always_ff @(posedge clk) begin
        if (!por_n)             busy_cnt <= 0;
        else if (shutdown_busy) busy_cnt <= busy_cnt + 1;
        else                    busy_cnt <= 0;
    end

    AST_MASKED_READS_ZERO: assert property (@(posedge clk) disable iff (!por_n)
        (disable_map != '0) |=> ((rd_data[N-1:0] & $past(disable_map)) == '0)); // R4

    AST_RESET_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!por_n)
        (comreset_req != '0) |-> ((comreset_req & ~rd_data[N-1:0]) == '0)); // R6

    AST_RESET_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
        (comreset_req != '0) |=> ((comreset_req & $past(comreset_req)) == '0)); // R6

    AST_ACTIVE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!por_n)
        ((port_active & ~rd_data[N-1:0]) == '0)); // R8

    AST_ACTIVE_NEEDS_SPINUP: assert property (@(posedge clk) disable iff (!por_n)
        (port_active != '0) |-> ((port_active & ~$past(spinup)) == '0)); // R8

    AST_PRES_SET_BY_COMINIT: assert property (@(posedge clk) disable iff (!por_n)
        ((rd_data[16 +: N] & ~$past(rd_data[16 +: N]) & ~$past(cominit)) == '0)); // R5

    AST_PRES_HELD_ON_FALL: assert property (@(posedge clk) disable iff (!por_n)
        ((($past(rd_data[N-1:0]) & ~rd_data[N-1:0]) & (rd_data[16 +: N] ^ $past(rd_data[16 +: N]))) == '0)); // R9

    AST_SHUTDOWN_BOUND: assert property (@(posedge clk) disable iff (!por_n)
        busy_cnt <= BUSY_LIMIT); // R10
endmodule

bind port_link_ctl port_link_ctl_chk #(.N(NUM_PORTS)) u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .rd_data       (rd_data),
    .disable_map   (disable_map),
    .spinup        (spinup),
    .cominit       (cominit),
    .comreset_req  (comreset_req),
    .port_active   (port_active),
    .shutdown_busy (shutdown_busy)
);

// File: tb/port_link_ctl_test.sv
module port_link_ctl_test;
    localparam int STEP = 16;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        flr = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [7:0]  disable_map = '0;
    logic [7:0]  spinup = '0;
    logic [7:0]  cominit = '0;
    logic [7:0]  comreset_req;
    logic [7:0]  port_active;
    logic        shutdown_busy;

    int errors = 0;
    int checks = 0;
    bit started = 0;
    bit done = 0;

    always #4 clk = ~clk;

    port_link_ctl #(.NUM_PORTS(8), .STEP_CYCLES(STEP)) uut (
        .clk(clk), .por_n(por_n), .flr(flr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .disable_map(disable_map), .spinup(spinup),
        .cominit(cominit), .comreset_req(comreset_req), .port_active(port_active),
        .shutdown_busy(shutdown_busy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [7:0] m_en = '0, m_pres = '0, m_armed = '0, m_crst = '0, m_act = '0;
    bit m_busy = 0;
    int pend[$];
    int cur = -1;
    int tmr = 0;

    always @(posedge clk) begin
        if (!por_n) begin
            m_en = '0; m_pres = '0; m_armed = '0; m_crst = '0; m_act = '0;
            pend.delete(); cur = -1; tmr = 0;
        end else begin : mdl
            logic [7:0] nen, acc, fell;
            nen  = (wr_en ? wr_data[7:0] : m_en) & ~disable_map;
            acc  = cominit & m_armed & m_en;
            fell = m_en & ~nen;
            m_pres = m_pres | acc;
            if (cur >= 0) begin
                if (tmr == 0) begin m_pres[cur] = 1'b0; cur = -1; end
                else tmr--;
            end else if (pend.size() > 0) begin
                pend.sort();
                cur = pend.pop_front();
                tmr = STEP - 1;
            end
            for (int i = 0; i < 8; i++) if (fell[i]) pend.push_back(i);
            m_crst  = nen & ~m_en;
            m_armed = m_crst | (m_armed & nen & ~acc);
            m_act   = nen & spinup;
            m_en    = nen;
        end
        m_busy = (cur >= 0) || (pend.size() > 0);
    end

    always @(negedge clk) begin
        if (started) begin
            chk("R1 model rd_data", rd_data, {8'h00, m_pres, 8'h00, m_en});
            chk("R6 model comreset_req", {24'h0, comreset_req}, {24'h0, m_crst});
            chk("R8 model port_active", {24'h0, port_active}, {24'h0, m_act});
            chk("R10 model shutdown_busy", {31'h0, shutdown_busy}, {31'h0, m_busy});
        end
    end

    task automatic wr(input logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulse_cominit(input logic [7:0] v);
        @(negedge clk); cominit = v;
        @(negedge clk); cominit = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        started = 1;
        // R2: reset state
        chk("R2 reset rd_data", rd_data, 32'h0);
        chk("R2 reset outputs", {15'h0, shutdown_busy, comreset_req, port_active}, 32'h0);
        por_n = 1'b1;
        @(negedge clk);

        // R1 R4 R6: write all ones with ports 1 and 3 masked
        disable_map = 8'h0A;
        wr(32'hFFFF_FFFF);
        chk("R1 R4 enable pattern", rd_data, 32'h0000_00F5);
        chk("R6 pulse on rise", {24'h0, comreset_req}, 32'h0000_00F5);
        @(negedge clk);
        chk("R6 pulse one cycle", {24'h0, comreset_req}, 32'h0);

        // R5: COMINIT on masked port 1 ignored, on armed ports 0,2,4 recorded
        pulse_cominit(8'h02);
        chk("R5 unsolicited ignored", rd_data, 32'h0000_00F5);
        pulse_cominit(8'h15);
        chk("R5 presence set", rd_data, 32'h0015_00F5);
        pulse_cominit(8'h01);
        chk("R5 repeat cominit stable", rd_data, 32'h0015_00F5);

        // R6 R7: rewrite same enables, presence bits written 0
        wr(32'h0000_00F5);
        chk("R6 no pulse on rewrite", {24'h0, comreset_req}, 32'h0);
        chk("R7 presence not writable", rd_data, 32'h0015_00F5);
        wr(32'h00EA_00F5);
        chk("R7 presence ones ignored", rd_data, 32'h0015_00F5);

        // R3: function-level reset ignored
        @(negedge clk); flr = 1'b1;
        @(negedge clk); flr = 1'b0;
        chk("R3 flr no effect", rd_data, 32'h0015_00F5);

        // R8: spin-up gated by enable
        spinup = 8'hFF;
        @(negedge clk); @(negedge clk);
        chk("R8 active equals enable", {24'h0, port_active}, 32'h0000_00F5);

        // R9 R10: disable every port, staggered shutdown
        wr(32'h0000_0000);
        chk("R9 presence held at fall", rd_data, 32'h0015_0000);
        chk("R10 busy raised", {31'h0, shutdown_busy}, 32'h1);
        chk("R8 inactive when disabled", {24'h0, port_active}, 32'h0);
        begin : shut
            int busy_cycles;
            busy_cycles = 1;
            for (int k = 1; k < STEP + 1; k++) begin
                @(negedge clk);
                if (shutdown_busy) busy_cycles++;
            end
            chk("R9 port0 still present", {31'h0, rd_data[16]}, 32'h1);
            @(negedge clk);
            if (shutdown_busy) busy_cycles++;
            chk("R9 port0 cleared in slot 0", rd_data, 32'h0014_0000);
            while (shutdown_busy) begin
                @(negedge clk);
                if (shutdown_busy) busy_cycles++;
            end
            chk("R10 busy cycles", busy_cycles, 6 * (STEP + 1));
            chk("R10 within 175 cycles", {31'h0, busy_cycles <= 175}, 32'h1);
            chk("R9 all presence cleared", rd_data, 32'h0);
        end

        // R4: mask set on an enabled port clears it
        disable_map = 8'h00;
        wr(32'h0000_0081);
        chk("R4 unmasked write", rd_data, 32'h0000_0081);
        @(negedge clk); disable_map = 8'h80;
        @(negedge clk);
        chk("R4 mask clears enable", rd_data, 32'h0000_0001);
        repeat (2 * (STEP + 2)) @(negedge clk);

        // R2: power-on reset mid activity
        por_n = 1'b0;
        @(negedge clk);
        chk("R2 reset clears", rd_data, 32'h0);
        chk("R2 reset outputs low", {15'h0, shutdown_busy, comreset_req, port_active}, 32'h0);
        por_n = 1'b1;
        repeat (2) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule